// File: doc/BRIEF.md
# Interleaved recursive moving-average filter

This block is a streaming boxcar averager for signed two's-complement samples. Each accepted sample is added to a running sum, and the sample that entered one window earlier is taken out of it. The new output is that sum scaled down by a right shift. The running sum is recursive, so one adder serves any window length. The cost is a delay line that holds the samples still inside the window.

Several channels can share the one datapath when their samples arrive strictly in turn. Each channel keeps its own window history and its own running sum. Both are held in delay lines that advance only on accepted samples. The input valid strobe and a user sideband field travel with the data at the same latency. Two compile-time switches add an input register stage and an output register stage. There is no back-pressure: the block takes a sample on every cycle where the input valid is high.

Top module: `ileave_boxcar_avg`

## Requirements
- R1: A synchronous reset clears the window history, every channel's running sum, `out_valid` and `out_data` to zero. The first WIN_LEN samples of each channel after reset are therefore averaged against zeros.
- R2: Let G = ceil(log2(WIN_LEN)). For an accepted sample on channel c, `out_data` is the sum of that sample and the WIN_LEN−1 samples before it on channel c, divided by 2^G and rounded toward minus infinity. Samples that were never received count as zero. The result is DATA_W bits wide.
- R3: When WIN_LEN is not a power of two, the same shift G is applied, so the gain is WIN_LEN/2^G, which is below one.
- R4: After reset, the k-th accepted sample (counting from 0) belongs to channel k mod NUM_CH. A channel's result depends only on that channel's samples.
- R5: On a cycle with `in_valid` low, `in_data` and `in_user` are ignored and no channel state changes.
- R6: `out_valid` equals `in_valid` delayed by LAT = 1 + REG_IN + REG_OUT cycles. The input side applies no back-pressure.
- R7: When `out_valid` is high, `out_user` carries the `in_user` value of the same sample, after the same latency as R6.
- R8: The internal sum is DATA_W+G bits wide and wraps on overflow. Full-scale inputs still give the exact R2 result: with a power-of-two window, a run of the most positive value gives that value back, and a run of the most negative value gives that value back.
- R9: While `out_valid` is low, `out_data` keeps the last result that was produced (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_user | input | USER_W | Sideband value carried with the sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_user | output | USER_W | Sideband value of the result's sample |
| out_data | output | DATA_W | Signed windowed mean |

## Verification
The hardest state to reach from the ports is a full-scale window that is being refilled while gaps in the valid stream keep moving which clock cycle carries which channel. If a channel slips, or the wrapping sum is handled wrongly, the error shows up only as a wrong mean some samples later. To reach this state, the stimulus runs long saturated stretches at both extremes, then mixes extremes with random valid gaps, and then resets in mid-stream and ramps up again. Two instances run side by side: one with a non-power-of-two window, three channels and both register stages; one with a power-of-two window, two channels and no register stages.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

  // Extra sum bits needed for a window of len samples; also the output shift.
  function automatic int growth_bits(input int len);
    return (len <= 1) ? 0 : $clog2(len);
  endfunction

endpackage

// File: rtl/boxcar_shift_line.sv
module boxcar_shift_line #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (adv) begin
      mem[0] <= d;
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
    end
  end

  assign q = mem[DEPTH-1];

endmodule

// File: rtl/boxcar_opt_stage.sv
module boxcar_opt_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/boxcar_core.sv
module boxcar_core #(
  parameter int DATA_W  = 16,
  parameter int WIN_LEN = 16,
  parameter int NUM_CH  = 1,
  parameter int USER_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_i,
  input  logic [USER_W-1:0] u_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              v_o,
  output logic [USER_W-1:0] u_o,
  output logic [DATA_W-1:0] y_o
);

  localparam int G      = boxcar_pkg::growth_bits(WIN_LEN);
  localparam int ACC_W  = DATA_W + G;
  localparam int HIST_D = WIN_LEN * NUM_CH;

  logic [DATA_W-1:0]       x_old;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_fb;
  logic signed [ACC_W-1:0] acc_nx;

  // Window history: the sample leaving the window of the current channel.
  boxcar_shift_line #(.W(DATA_W), .DEPTH(HIST_D)) u_hist (
    .clk(clk), .rst(rst), .adv(v_i), .d(x_i), .q(x_old)
  );

  // Sum feedback: reaches back NUM_CH accepted samples to the same channel.
  generate
    if (NUM_CH == 1) begin : g_fb_direct
      assign acc_fb = acc_q;
    end else begin : g_fb_line
      logic [ACC_W-1:0] fb_raw;
      boxcar_shift_line #(.W(ACC_W), .DEPTH(NUM_CH - 1)) u_fb (
        .clk(clk), .rst(rst), .adv(v_i), .d(acc_q), .q(fb_raw)
      );
      assign acc_fb = $signed(fb_raw);
    end
  endgenerate

  assign acc_nx = ACC_W'($signed(x_i)) - ACC_W'($signed(x_old)) + acc_fb;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      v_o   <= 1'b0;
      u_o   <= '0;
    end else begin
      v_o <= v_i;
      u_o <= u_i;
      if (v_i) acc_q <= acc_nx;
    end
  end

  // Arithmetic shift by G and truncation to DATA_W, taken as one slice.
  assign y_o = acc_q[G +: DATA_W];

endmodule

// File: rtl/ileave_boxcar_avg.sv
module ileave_boxcar_avg #(
  parameter int DATA_W  = 16,
  parameter int WIN_LEN = 16,
  parameter int NUM_CH  = 1,
  parameter int USER_W  = 1,
  parameter bit REG_IN  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [USER_W-1:0] in_user,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [USER_W-1:0] out_user,
  output logic [DATA_W-1:0] out_data
);

  localparam int LANE_W = 1 + USER_W + DATA_W;
  localparam int LAT_C  = 1 + (REG_IN ? 1 : 0) + (REG_OUT ? 1 : 0);

  logic [LANE_W-1:0] in_lane, core_lane_i, core_lane_o, out_lane;
  logic              core_vi, core_vo;
  logic [USER_W-1:0] core_ui, core_uo;
  logic [DATA_W-1:0] core_xi, core_y;

  assign in_lane = {in_valid, in_user, in_data};

  boxcar_opt_stage #(.W(LANE_W), .EN(REG_IN)) u_in_stage (
    .clk(clk), .rst(rst), .d(in_lane), .q(core_lane_i)
  );

  assign {core_vi, core_ui, core_xi} = core_lane_i;

  boxcar_core #(
    .DATA_W(DATA_W), .WIN_LEN(WIN_LEN), .NUM_CH(NUM_CH), .USER_W(USER_W)
  ) u_core (
    .clk(clk), .rst(rst),
    .v_i(core_vi), .u_i(core_ui), .x_i(core_xi),
    .v_o(core_vo), .u_o(core_uo), .y_o(core_y)
  );

  assign core_lane_o = {core_vo, core_uo, core_y};

  boxcar_opt_stage #(.W(LANE_W), .EN(REG_OUT)) u_out_stage (
    .clk(clk), .rst(rst), .d(core_lane_o), .q(out_lane)
  );

  assign {out_valid, out_user, out_data} = out_lane;

endmodule

// File: rtl/boxcar_chk.sv
module boxcar_chk #(
  parameter int LAT    = 3,
  parameter int USER_W = 1,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [USER_W-1:0] in_user,
  input logic              out_valid,
  input logic [USER_W-1:0] out_user,
  input logic              core_vi,
  input logic [DATA_W-1:0] core_y
);

  int since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 0;
    else if (since_rst < LAT) since_rst <= since_rst + 1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == LAT) |-> (out_valid == $past(in_valid, LAT)));  // R6

  AST_USER_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == LAT && out_valid) |-> (out_user == $past(in_user, LAT)));  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !core_vi |=> $stable(core_y));  // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && core_y == '0));  // R1

endmodule

bind ileave_boxcar_avg boxcar_chk #(.LAT(LAT_C), .USER_W(USER_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_user(in_user),
  .out_valid(out_valid), .out_user(out_user), .core_vi(core_vi), .core_y(core_y)
);

// File: tb/tb_ileave_boxcar_avg.sv
`timescale 1ns/1ps
module tb_ileave_boxcar_avg;
  localparam int DW = 12;
  localparam int UW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [UW-1:0] in_user = '0;
  logic [DW-1:0] in_data = '0;
  logic a_v, b_v;
  logic [UW-1:0] a_u, b_u;
  logic [DW-1:0] a_d, b_d;

  always #2.5 clk = ~clk;

  // A: window 6 (non power of two), 3 channels, both stages, latency 3
  ileave_boxcar_avg #(.DATA_W(DW), .WIN_LEN(6), .NUM_CH(3), .USER_W(UW),
                      .REG_IN(1'b1), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_user(in_user), .in_data(in_data),
    .out_valid(a_v), .out_user(a_u), .out_data(a_d));

  // B: window 8, 2 channels, no stages, latency 1
  ileave_boxcar_avg #(.DATA_W(DW), .WIN_LEN(8), .NUM_CH(2), .USER_W(UW),
                      .REG_IN(1'b0), .REG_OUT(1'b0)) dut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_user(in_user), .in_data(in_data),
    .out_valid(b_v), .out_user(b_u), .out_data(b_d));

  typedef struct { int v; int u; int d; } ent_t;

  int    smp[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  ent_t  pa[3];
  int    hold_a = 0;
  int    hold_b = 0;

  function automatic int ref_mean(int ch, int len, int g);
    int n = smp.size() - 1;
    int s = 0;
    for (int k = 0; k < len; k++) begin
      int idx = n - k * ch;
      if (idx >= 0) s += smp[idx];
    end
    return s >>> g;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Called at a falling edge; the inputs still hold what the last rising edge took.
  task automatic observe();
    ent_t ea;
    int   eb;
    if (rst) begin
      smp.delete();
      hold_a = 0;
      hold_b = 0;
      for (int i = 0; i < 3; i++) pa[i] = '{0, 0, 0};
      chk("R1 reset dut out_valid", int'(a_v), 0);
      chk("R1 reset dut_b out_valid", int'(b_v), 0);
      chk("R1 reset dut_b out_data", int'($signed(b_d)), 0);
      return;
    end
    ea = '{int'(in_valid), int'(in_user), 0};
    eb = 0;
    if (in_valid) begin
      smp.push_back(int'($signed(in_data)));
      ea.d = ref_mean(3, 6, 3);
      eb   = ref_mean(2, 8, 3);
    end
    pa[2] = pa[1];
    pa[1] = pa[0];
    pa[0] = ea;
    chk("R6 dut out_valid", int'(a_v), pa[2].v);
    if (pa[2].v != 0) begin
      chk("R7 dut out_user", int'(a_u), pa[2].u);
      chk({tag, " R3 R4 dut out_data"}, int'($signed(a_d)), pa[2].d);
      hold_a = pa[2].d;
    end else begin
      chk("R9 dut idle out_data", int'($signed(a_d)), hold_a);
    end
    chk("R6 dut_b out_valid", int'(b_v), int'(in_valid));
    if (in_valid) begin
      chk("R7 dut_b out_user", int'(b_u), int'(in_user));
      chk({tag, " R2 R4 dut_b out_data"}, int'($signed(b_d)), eb);
      hold_b = eb;
    end else begin
      chk("R9 dut_b idle out_data", int'($signed(b_d)), hold_b);
    end
  endtask

  task automatic cyc(int v, int u, int d);
    @(negedge clk);
    observe();
    rst      = 1'b0;
    in_valid = (v != 0);
    in_user  = u[UW-1:0];
    in_data  = d[DW-1:0];
  endtask

  task automatic rst_cyc();
    @(negedge clk);
    observe();
    rst      = 1'b1;
    in_valid = 1'b0;
  endtask

  function automatic int rnd_data();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    repeat (3) rst_cyc();
    // R1: ramp from zero with a constant input
    tag = "R1";
    repeat (30) cyc(1, 1, 1000);
    // R4: continuous interleaved random stream
    tag = "R4";
    repeat (200) cyc(1, int'($urandom_range(0, 15)), rnd_data());
    // R5: random gaps carrying junk data and user values
    tag = "R5";
    repeat (300) cyc(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)), rnd_data());
    // R8: full scale runs, then extremes mixed with gaps
    tag = "R8";
    repeat (60) cyc(1, 5, 2047);
    repeat (60) cyc(1, 10, -2048);
    repeat (80) cyc(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                    ($urandom_range(0, 1) != 0) ? 2047 : -2048);
    // R1: reset in mid-stream and ramp up again
    tag = "R1";
    repeat (2) rst_cyc();
    repeat (20) cyc(1, 3, -700);
    repeat (6) cyc(0, 0, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule